// File: doc/BRIEF.md
# Free-Running Count-Up Timer with Suspend Gating

This block is a free-running up-counter for timestamping and interval measurement, with a small byte-wide register port. The counter advances on a tick enable taken either from every cycle of the reference clock or from a divide-by-27 prescaler. Software picks the rate in a configuration register. A sticky wrap flag records each time the counter's top bit falls from 1 to 0, which is each time the counter rolls over. Software clears the flag by writing 1 to it. An interrupt level is the flag masked by an enable bit.

A power-down control bit can freeze the count while an external suspend input is high. The bit clears itself when suspend is released, so counting resumes without software acting. The register port is synchronous, with address, write strobe, write data and registered read data one cycle after the address. Software reads the count as four bytes, least significant byte first, and cannot write it.

Top module: `freerun_timer`

## Requirements
- R1: On each tick the counter adds 1, modulo 2^CNT_W. It resets to 0. Bytes 08h, 09h, 0Ah and 0Bh return count bits 7:0, 15:8, 23:16 and 31:24, and any bits above CNT_W-1 read 0.
- R2: Status bit 0 at offset 0Ch is set when counter bit CNT_W-1 goes from 1 to 0, and it stays set until cleared.
- R3: Writing a 1 to bit 0 of offset 0Ch clears the flag, and writing 0 there leaves it unchanged. If a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R4: Config bit 1 at offset 0Dh selects the rate. With 1 the counter ticks every clock. With 0 it ticks exactly once per 27 clocks.
- R5: irq_o is high exactly when the status flag is 1 and config bit 0 (interrupt enable) is 1.
- R6: With config bit 2 (power-down) at 1 and suspend_i high, the count holds. With bit 2 at 0, suspend_i has no effect on counting.
- R7: Config bit 2 clears on the clock after suspend_i falls from 1 to 0. This takes priority over a write in the same cycle.
- R8: Reserved bits (status 7:1, config 7:3) read 0 and ignore writes. Offsets 0Eh, 0Fh and any other unmapped offset read 0.
- R9: Writes to offsets 08h to 0Bh do not change the count.
- R10: rd_data_o presents the byte addressed on the previous clock edge.
- R11: After reset, status, config and irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (27 MHz) |
| rst_n | input | 1 | Active-low power-on reset |
| suspend_i | input | 1 | Active-high low-power request |
| addr_i | input | ADDR_W | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, one cycle after addr_i |
| irq_o | output | 1 | Interrupt level |

## Verification
A counter wrap that sets the status flag and a software write-1-to-clear of that same flag can land on one clock edge. The bench provokes this by freezing the counter through power-down and suspend, reading the frozen value and computing how many full-rate ticks remain before the rollover. It then releases suspend and drives the clearing write on exactly the wrapping edge. The flag must read back as 1, and the counter's upper byte must show that the wrap really happened on that edge.

// File: rtl/frt_pkg.sv
package frt_pkg;
   localparam int unsigned CNT_BASE = 8;   // count bytes 8..11
   localparam int unsigned STS_OFS  = 12;
   localparam int unsigned CFG_OFS  = 13;

   typedef struct packed {
      logic pd;     // bit 2: stop while suspended
      logic fast;   // bit 1: full rate
      logic ien;    // bit 0: interrupt enable
   } frt_cfg_t;
endpackage

// File: rtl/frt_prescale.sv
module frt_prescale #(
   parameter int unsigned DIV = 27
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic fast_i,
   output logic tick_o
);
   generate
      if (DIV < 2) begin : g_nodiv
         assign tick_o = run_i;
         logic unused_fast;
         assign unused_fast = fast_i ^ clk ^ rst_n;
      end else begin : g_div
         localparam int unsigned DW = $clog2(DIV);
         logic [DW-1:0] div_q;
         logic          last;
         assign last = (div_q == DW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     div_q <= '0;
            else if (run_i) div_q <= last ? '0 : div_q + 1'b1;
         end
         assign tick_o = run_i & (fast_i | last);
      end
   endgenerate
endmodule

// File: rtl/frt_count.sv
module frt_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
   end
   // top bit falls only when all ones roll to zero
   assign wrap_o = tick_i & (&cnt_q);
   assign cnt_o  = cnt_q;
endmodule

// File: rtl/frt_regs.sv
module frt_regs
   import frt_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              suspend_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [7:0]        wr_data_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              wrap_i,
   output frt_cfg_t          cfg_o,
   output logic              flag_o,
   output logic [7:0]        rd_data_o
);
   frt_cfg_t    cfg_q;
   logic        flag_q, susp_q, release_evt;
   logic        sel_sts, sel_cfg, sel_cnt;
   logic [31:0] cnt_ext;
   logic [7:0]  rd_d, rd_q;

   assign sel_sts = (addr_i == ADDR_W'(STS_OFS));
   assign sel_cfg = (addr_i == ADDR_W'(CFG_OFS));
   assign sel_cnt = (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(CNT_BASE >> 2));
   assign release_evt = susp_q & ~suspend_i;
   assign cnt_ext = 32'(cnt_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         susp_q <= 1'b0;
         flag_q <= 1'b0;
         cfg_q  <= '0;
      end else begin
         susp_q <= suspend_i;
         if (wr_en_i && sel_sts && wr_data_i[0]) flag_q <= 1'b0;
         if (wrap_i)                             flag_q <= 1'b1;
         if (wr_en_i && sel_cfg)                 cfg_q  <= frt_cfg_t'(wr_data_i[2:0]);
         if (release_evt)                        cfg_q.pd <= 1'b0;
      end
   end

   always_comb begin
      rd_d = '0;
      if (sel_cnt)      rd_d = cnt_ext[{addr_i[1:0], 3'b000} +: 8];
      else if (sel_sts) rd_d = {7'b0, flag_q};
      else if (sel_cfg) rd_d = {5'b0, cfg_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= rd_d;
   end

   logic unused_wdata;
   assign unused_wdata = ^wr_data_i[7:3];

   assign cfg_o     = cfg_q;
   assign flag_o    = flag_q;
   assign rd_data_o = rd_q;
endmodule

// File: rtl/freerun_timer.sv
module freerun_timer
   import frt_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DIV    = 27,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              suspend_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [7:0]        wr_data_i,
   output logic [7:0]        rd_data_o,
   output logic              irq_o
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("freerun_timer: CNT_W must be 2..32");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("freerun_timer: ADDR_W must be at least 4");
      end
   endgenerate

   frt_cfg_t         cfg_w;
   logic             tick_w, wrap_w, sts_flag, run_w;
   logic [CNT_W-1:0] cnt_w;

   assign run_w = ~(cfg_w.pd & suspend_i);

   frt_prescale #(.DIV(DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .run_i(run_w), .fast_i(cfg_w.fast), .tick_o(tick_w)
   );

   frt_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .cnt_o(cnt_w), .wrap_o(wrap_w)
   );

   frt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .suspend_i(suspend_i), .addr_i(addr_i),
      .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .cnt_i(cnt_w), .wrap_i(wrap_w),
      .cfg_o(cfg_w), .flag_o(sts_flag), .rd_data_o(rd_data_o)
   );

   assign irq_o = sts_flag & cfg_w.ien;
endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              suspend_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [7:0]        rd_data_o,
   input logic              irq_o,
   input logic [CNT_W-1:0]  cnt,
   input logic              flag,
   input logic [2:0]        cfg
);
   // R1: count moves by 0 or +1 per cycle
   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

   // R2: falling top bit leaves the flag set
   assert_wrap_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnt[CNT_W-1]) |-> flag);

   // R4: full rate and not gated -> increments next cycle
   assert_fast_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[1] && !(cfg[2] && suspend_i)) |=> cnt == CNT_W'($past(cnt) + 1'b1));

   // R5: interrupt never rises without enable
   assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flag && cfg[0]));

   // R6: gated count holds
   assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[2] && suspend_i) |=> $stable(cnt));

   // R7: release of suspend clears power-down
   assert_pd_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(suspend_i) |=> !cfg[2]);

   // R8: reserved offset reads zero
   assert_rsvd_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == ADDR_W'(14) || addr_i == ADDR_W'(15)) |=> rd_data_o == 8'h00);
endmodule

bind freerun_timer frt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .suspend_i(suspend_i), .addr_i(addr_i),
   .rd_data_o(rd_data_o), .irq_o(irq_o), .cnt(cnt_w), .flag(sts_flag), .cfg(cfg_w)
);

// File: tb/freerun_timer_test.sv
module freerun_timer_test;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 10;               // small counter so wraps come quickly
   localparam int WRAP = 1 << CW;

   logic       clk = 0, rst_n = 0, suspend_i = 0, wr_en_i = 0;
   logic [3:0] addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic [7:0] rd_data_o;
   logic       irq_o;
   int tests = 0, fails = 0;

   freerun_timer #(.CNT_W(CW), .DIV(27), .ADDR_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .suspend_i(suspend_i), .addr_i(addr_i),
      .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); addr_i = a; wr_data_i = d; wr_en_i = 1;
      @(negedge clk); wr_en_i = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); addr_i = a; wr_en_i = 0;
      @(negedge clk); d = rd_data_o;
   endtask

   task automatic read_cnt(output int c);
      logic [7:0] lo, hi;
      rd(4'h8, lo); rd(4'h9, hi);
      c = {hi, lo};
   endtask

   // byte0 difference across M idle cycles: captures are M+2 edges apart
   task automatic rate_diff(input int m, output int diff);
      logic [7:0] a, b;
      rd(4'h8, a);
      repeat (m) @(negedge clk);
      rd(4'h8, b);
      diff = int'(8'(b - a));
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(4'hC, d); chk("R11 status after reset", d, 0);
      rd(4'hD, d); chk("R11 config after reset", d, 0);
      chk("R11 irq after reset", irq_o, 0);
   endtask

   task automatic t_rates();
      int diff;
      wr(4'hD, 8'h02);
      rate_diff(10, diff); chk("R4 R10 full rate 12 edges", diff, 12);
      wr(4'hD, 8'h00);
      rate_diff(79, diff); chk("R4 divided rate 81 edges", diff, 3);
      rate_diff(133, diff); chk("R4 divided rate 135 edges", diff, 5);
   endtask

   task automatic t_reserved();
      logic [7:0] d;
      wr(4'hD, 8'hF8); rd(4'hD, d); chk("R8 config reserved ignored", d, 8'h00);
      wr(4'hD, 8'hFF); rd(4'hD, d); chk("R8 config reads 07", d, 8'h07);
      rd(4'hE, d); chk("R8 offset 0E", d, 0);
      rd(4'hF, d); chk("R8 offset 0F", d, 0);
      rd(4'h3, d); chk("R8 unmapped offset", d, 0);
      rd(4'hB, d); chk("R1 bits above width read 0", d, 0);
      wr(4'hD, 8'h02);
   endtask

   task automatic t_gate();
      logic [7:0] a, b, d;
      int diff;
      wr(4'hD, 8'h06);
      @(negedge clk); suspend_i = 1;
      rd(4'h8, a);
      repeat (20) @(negedge clk);
      rd(4'h8, b); chk("R6 held while suspended", b, a);
      wr(4'h8, 8'h55); wr(4'h9, 8'hAA);
      rd(4'h8, b); chk("R9 count write ignored", b, a);
      rd(4'hD, d); chk("R7 pd still set during suspend", d, 8'h06);
      @(negedge clk); suspend_i = 0;
      @(negedge clk);
      rd(4'hD, d); chk("R7 pd cleared on release", d, 8'h02);
      @(negedge clk); suspend_i = 1;
      rate_diff(10, diff); chk("R6 pd=0 suspend no effect", diff, 12);
      @(negedge clk); suspend_i = 0;
   endtask

   task automatic t_wrap();
      logic [7:0] d;
      bit seen = 0;
      wr(4'hD, 8'h02);
      wr(4'hC, 8'h01);
      for (int i = 0; i < 1200 && !seen; i++) begin
         rd(4'hC, d);
         if (d[0]) seen = 1;
      end
      chk("R2 flag set by wrap", seen, 1);
      chk("R5 irq low while disabled", irq_o, 0);
      wr(4'hD, 8'h03); chk("R5 irq high when enabled", irq_o, 1);
      wr(4'hC, 8'h00); rd(4'hC, d); chk("R3 write 0 keeps flag", d, 1);
      wr(4'hC, 8'h01); rd(4'hC, d); chk("R3 write 1 clears flag", d, 0);
      chk("R5 irq low after clear", irq_o, 0);
   endtask

   task automatic t_collide();
      logic [7:0] d;
      int c, k;
      k = 0;
      while (k < 4) begin
         wr(4'hD, 8'h06);
         @(negedge clk); suspend_i = 1;
         read_cnt(c);
         k = WRAP - c;
         if (k < 4) begin
            @(negedge clk); suspend_i = 0;
            repeat (10) @(negedge clk);
         end
      end
      wr(4'hC, 8'h01);
      @(negedge clk); suspend_i = 0;
      repeat (k - 1) @(negedge clk);
      addr_i = 4'hC; wr_data_i = 8'h01; wr_en_i = 1;
      @(negedge clk); wr_en_i = 0;
      rd(4'hC, d); chk("R3 set wins over clear", d, 1);
      rd(4'h9, d); chk("R2 wrap occurred on that edge", d, 0);
      wr(4'hC, 8'h01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_rates();
      t_reserved();
      t_gate();
      t_wrap();
      t_collide();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule